// File: doc/BRIEF.md
# Signed Halfword Multiply-Accumulate Unit

This execution unit serves a 32-bit processor datapath. For each qualified instruction it takes one 16-bit half from the multiplicand operand and one from the multiplier operand. Each half is chosen by its own opcode bit. The unit sign-extends both halves, forms a 32-bit signed product and adds the accumulate operand to it. The sum wraps modulo 2^32 and is never saturated.

When the signed addition overflows, the unit sets a sticky saturation flag (Q). It never clears Q. The N, Z, C and V flags pass through unchanged. A destination index of 15 (the program counter) turns the operation into a no-op. Encodings outside the supported class, and every encoding when the architecture version parameter is below 5, produce a one-cycle illegal-instruction pulse.

The register file supplies the three operand values. This unit only decodes the instruction word for the half selects, the destination index and legality. All results appear registered, one clock after the strobe.

Top module: `halfword_mac`

## Requirements
- R1: The destination index `out_rd` equals `instr[19:16]` of the instruction that caused the write.
- R2: `instr[5]` selects the multiplicand half and `instr[6]` selects the multiplier half. A 0 picks bits 15:0 and a 1 picks bits 31:16, independently for each operand.
- R3: Both selected halves are treated as signed 16-bit values. Their product is kept as a 32-bit signed value.
- R4: `out_result` equals the product plus `acc_val`, wrapped to 32 bits and never saturated.
- R5: Overflow means both addends have the same sign and the sum's sign differs from it. On a write, Q out = Q in OR overflow, so a set Q stays set.
- R6: When `instr[19:16]` is 15, no write occurs and `status_out` equals `status_in`, even if the addition overflows.
- R7: The status vector is ordered {N,Z,C,V,Q}, with Q at bit 0 directly below V. Bits 4:1 of `status_out` equal bits 4:1 of `status_in` for every accepted instruction.
- R8: An instruction is supported only when `instr[27:20]` is 8'h10, `instr[7]` is 1 and `instr[4]` is 0; `instr[31:28]` is ignored. Any other encoding gives `out_illegal`, no write and an unchanged status.
- R9: Outputs update one cycle after `in_valid`. `out_we` and `out_illegal` are single-cycle pulses, and a cycle without `in_valid` produces neither.
- R10: With `ARCH_VER` below 5, every accepted instruction is reported illegal and nothing is written.
- R11: Under reset, `out_we`, `out_illegal`, `out_rd`, `out_result` and `status_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies the instruction and operands this cycle |
| instr | input | 32 | Instruction word |
| rm_val | input | 32 | Multiplicand register value |
| rs_val | input | 32 | Multiplier register value |
| acc_val | input | 32 | Accumulate register value |
| status_in | input | 5 | Current flags {N,Z,C,V,Q} |
| out_we | output | 1 | Register write enable pulse |
| out_illegal | output | 1 | Unsupported-encoding pulse |
| out_rd | output | 4 | Destination register index |
| out_result | output | 32 | Accumulated result |
| status_out | output | 5 | Updated flags {N,Z,C,V,Q} |

## Verification
The bench targets the two extreme halfword products: -32768 times -32768, which gives 0x40000000, and -32768 times 32767. Added to accumulators near the limits, these overflow in both directions. A unit that zero-extended the halves, saturated the sum or used an unsigned carry would produce a wrong result or a wrong Q.

Separate cases cover:
- a set Q with no overflow, which catches a unit that clears the flag;
- destination 15 with an overflowing sum, which catches a flag or write leak;
- encodings that differ from the supported one in a single bit, which catch loose decoding;
- all four half selections with distinct halves, which catch swapped select bits.

A second instance at version 4 must flag every instruction as illegal.

// File: rtl/halfword_mac.sv
module halfword_mac #(
  parameter int ARCH_VER = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] instr,
  input  logic [31:0] rm_val,
  input  logic [31:0] rs_val,
  input  logic [31:0] acc_val,
  input  logic [4:0]  status_in,
  output logic        out_we,
  output logic        out_illegal,
  output logic [3:0]  out_rd,
  output logic [31:0] out_result,
  output logic [4:0]  status_out
);
  localparam bit HAS_MAC = (ARCH_VER >= 5);
  localparam logic [3:0] PC_IDX = 4'hF;

  logic        is_mac, legal, writes, ovf;
  logic [15:0] a_half, b_half;
  logic [31:0] a_ext, b_ext, prod, sum;

  assign is_mac = (instr[27:20] == 8'h10) && instr[7] && !instr[4];
  assign legal  = HAS_MAC && is_mac;
  assign writes = in_valid && legal && (instr[19:16] != PC_IDX);

  assign a_half = instr[5] ? rm_val[31:16] : rm_val[15:0];
  assign b_half = instr[6] ? rs_val[31:16] : rs_val[15:0];
  assign a_ext  = {{16{a_half[15]}}, a_half};
  assign b_ext  = {{16{b_half[15]}}, b_half};
  assign prod   = a_ext * b_ext;
  assign sum    = prod + acc_val;
  assign ovf    = (prod[31] == acc_val[31]) && (sum[31] != prod[31]);

  logic unused_fields;
  assign unused_fields = ^{instr[31:28], instr[15:8], instr[3:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_we      <= 1'b0;
      out_illegal <= 1'b0;
      out_rd      <= '0;
      out_result  <= '0;
      status_out  <= '0;
    end else begin
      out_we      <= writes;
      out_illegal <= in_valid && !legal;
      if (in_valid)
        status_out <= {status_in[4:1], status_in[0] | (writes & ovf)};
      if (writes) begin
        out_rd     <= instr[19:16];
        out_result <= sum;
      end
    end
  end

  AST_NO_PC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    out_we |-> (out_rd != PC_IDX)); // R6
  AST_Q_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && status_in[0]) |=> status_out[0]); // R5
  AST_NZCV_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (status_out[4:1] == $past(status_in[4:1]))); // R7
  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_we && out_illegal)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_we && !out_illegal)); // R9

  if (!HAS_MAC) begin : g_old_arch
    AST_OLD_ARCH_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_illegal && !out_we)); // R10
  end
endmodule

// File: tb/halfword_mac_bench.sv
`timescale 1ns/1ps
module halfword_mac_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0, rm_val = '0, rs_val = '0, acc_val = '0;
  logic [4:0]  status_in = '0;
  logic        out_we, out_illegal, v4_we, v4_illegal;
  logic [3:0]  out_rd, v4_rd;
  logic [31:0] out_result, v4_result;
  logic [4:0]  status_out, v4_status;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  halfword_mac #(.ARCH_VER(5)) u_halfword_mac (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .rm_val(rm_val), .rs_val(rs_val), .acc_val(acc_val), .status_in(status_in),
    .out_we(out_we), .out_illegal(out_illegal), .out_rd(out_rd),
    .out_result(out_result), .status_out(status_out));

  halfword_mac #(.ARCH_VER(4)) u_halfword_mac_v4 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .rm_val(rm_val), .rs_val(rs_val), .acc_val(acc_val), .status_in(status_in),
    .out_we(v4_we), .out_illegal(v4_illegal), .out_rd(v4_rd),
    .out_result(v4_result), .status_out(v4_status));

  typedef struct {
    logic        we;
    logic        ill;
    logic [3:0]  rd;
    logic [31:0] res;
    logic [4:0]  st;
    string       tag;
  } exp_t;

  exp_t sb[$];
  logic valid_d = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit hi_rm, input bit hi_rs, input logic [3:0] rd);
    return {4'hE, 8'h10, rd, 4'h2, 4'h3, 1'b1, hi_rs, hi_rm, 1'b0, 4'h1};
  endfunction

  task automatic drive(input logic [31:0] i, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] c, input logic [4:0] st, input string tag);
    exp_t e;
    bit ok_enc;
    longint pa, pb, p, s;
    logic [31:0] p32, s32;
    bit v;
    @(negedge clk);
    instr = i; rm_val = a; rs_val = b; acc_val = c; status_in = st; in_valid = 1'b1;
    ok_enc = (i[27:20] == 8'h10) && i[7] && !i[4];
    pa = i[5] ? longint'($signed(a[31:16])) : longint'($signed(a[15:0]));
    pb = i[6] ? longint'($signed(b[31:16])) : longint'($signed(b[15:0]));
    p = pa * pb;
    s = p + longint'($signed(c));
    p32 = p[31:0];
    s32 = s[31:0];
    v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
    e.tag = tag;
    e.ill = !ok_enc;
    e.we  = ok_enc && (i[19:16] != 4'hF);
    e.rd  = i[19:16];
    e.res = s32;
    e.st  = e.we ? {st[4:1], st[0] | v} : st;
    if (p32 == 32'hx) e.res = 'x;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  always @(posedge clk) valid_d <= rst_n && in_valid;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (valid_d && sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk(out_we == e.we, {e.tag, " we"}, 32'(out_we), 32'(e.we));
        chk(out_illegal == e.ill, {e.tag, " R8 illegal"}, 32'(out_illegal), 32'(e.ill));
        chk(status_out == e.st, {e.tag, " R5 R6 R7 status"}, 32'(status_out), 32'(e.st));
        if (e.we) begin
          chk(out_rd == e.rd, {e.tag, " R1 rd"}, 32'(out_rd), 32'(e.rd));
          chk(out_result == e.res, {e.tag, " R4 result"}, out_result, e.res);
        end
        chk(v4_illegal && !v4_we, "R10 old arch illegal", {v4_illegal, v4_we}, 32'h2);
      end else if (!valid_d) begin
        chk(!out_we && !out_illegal, "R9 idle quiet", {out_we, out_illegal}, 32'h0);
      end
    end
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_we == 0 && out_illegal == 0, "R11 reset pulses", {out_we, out_illegal}, 32'h0);
    chk(out_result == 0 && out_rd == 0, "R11 reset data", out_result, 32'h0);
    chk(status_out == 0, "R11 reset status", 32'(status_out), 32'h0);
    rst_n = 1'b1;
    idle(2);

    drive(mk(0, 0, 4'd1), 32'h0003_0005, 32'h0007_0009, 32'd100, 5'b10100, "R2 bb");
    drive(mk(1, 0, 4'd2), 32'h0003_0005, 32'h0007_0009, 32'd100, 5'b01010, "R2 tb");
    drive(mk(0, 1, 4'd3), 32'h0003_0005, 32'h0007_0009, 32'd100, 5'b00000, "R2 bt");
    drive(mk(1, 1, 4'd4), 32'h0003_0005, 32'h0007_0009, 32'd100, 5'b11110, "R2 tt");
    idle(1);
    drive(mk(0, 0, 4'd5), 32'h0000_FFFE, 32'h0000_0003, 32'd0, 5'b0, "R3 neg x pos");
    drive(mk(1, 1, 4'd6), 32'h8000_0000, 32'h8000_0000, 32'd0, 5'b0, "R3 min x min");
    drive(mk(0, 0, 4'd7), 32'h0000_7FFF, 32'h0000_7FFF, 32'h7FFF_FFFF, 5'b0, "R5 pos overflow");
    drive(mk(1, 0, 4'd8), 32'h8000_0000, 32'h0000_7FFF, 32'h8000_0000, 5'b0, "R5 neg overflow");
    drive(mk(0, 0, 4'd9), 32'h0000_0002, 32'h0000_0002, 32'd1, 5'b00001, "R5 sticky Q");
    drive(mk(1, 1, 4'd10), 32'h8000_0000, 32'h8000_0000, 32'h4000_0000, 5'b0, "R4 wrap no saturate");
    idle(2);
    drive(mk(0, 0, 4'hF), 32'h0000_7FFF, 32'h0000_7FFF, 32'h7FFF_FFFF, 5'b10100, "R6 pc dest");
    drive(mk(0, 0, 4'd3) | 32'h0000_0010, 32'h1, 32'h1, 32'h1, 5'b01000, "R8 bit4 set");
    drive(mk(0, 0, 4'd3) & ~32'h0000_0080, 32'h1, 32'h1, 32'h1, 5'b0, "R8 bit7 clear");
    drive(mk(0, 0, 4'd3) ^ 32'h0020_0000, 32'h1, 32'h1, 32'h1, 5'b00011, "R8 class bits");
    drive({4'h0, mk(1, 0, 4'd11)}, 32'h0002_0000, 32'h0000_0003, 32'd5, 5'b0, "R8 cond ignored");
    idle(3);
    for (int k = 0; k < 60; k++) begin
      drive(mk($urandom_range(0, 1), $urandom_range(0, 1), 4'($urandom_range(0, 15))),
            $urandom, $urandom, $urandom, 5'($urandom), "R4 random");
      if (k % 7 == 0) idle(1);
    end
    idle(4);
    chk(sb.size() == 0, "R9 all results seen", sb.size(), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule